// File: doc/BRIEF.md
# Lockable Video Sync Timing Generator

This block produces the raster timing for a composite video encoder. It runs from a master clock at four times the colour subcarrier. Horizontal and vertical counters step through every line and field of the selected TV standard. From those counts the block derives an active-low composite sync, a blanking flag and a one-in-four clock enable for the subcarrier logic. Two select pins choose one of three formats: NTSC-M, PAL-M or PAL-B/G. A third pin chooses between a full interlaced line count and a non-interlaced count that is one line shorter.

When the superimpose enable is high, the block follows an external video source. The external horizontal and vertical reset pins are active low. Each one is synchronised, and its falling edge clears the matching counter, so that the internal graphics stay aligned to the incoming picture. In the same mode the block drives a key signal. The key is high over the active picture and tells the downstream mixer when to show internal graphics in place of the external video.

Top module: `vsg_timing_top`

## Requirements
- R1: The format decodes from `{sel_a, sel_b}` as follows: 11 gives NTSC-M, 00 gives PAL-B/G, 01 gives PAL-M and 10 is treated as NTSC-M. The `fmt` output shows the decoded format one cycle later, coded as 0 for NTSC-M, 1 for PAL-B/G and 2 for PAL-M.
- R2: `h_cnt` rises by one each clock from 0 to the line length minus one and then returns to 0. The line length is `H_TOT_525` for NTSC-M and PAL-M and `H_TOT_625` for PAL-B/G. If a format change leaves the count at or past the new last value, the next count is 0.
- R3: `v_cnt` advances by one each time `h_cnt` wraps by itself and returns to 0 after its last line. The field has `V_TOT_525` or `V_TOT_625` lines when `line_full` is 1, and one line fewer when `line_full` is 0.
- R4: `fsc_en` is high for exactly one clock in every four. Its first pulse follows the fourth rising edge after reset is released.
- R5: `blank` is high when the previous cycle's `h_cnt` was below the horizontal blanking length or its `v_cnt` was below the vertical blanking line count. Both lengths depend on the format.
- R6: On lines where the previous `v_cnt` is below `VSYNC_LINES`, `csync_n` is high during the horizontal sync window and low elsewhere. On all other lines it is low during the horizontal sync window and high elsewhere. The sync window is the previous `h_cnt` below the format's sync length.
- R7: `key` is high when the previous cycle had `sup_en` high and was outside blanking, and is low otherwise.
- R8: With `sup_en` high, a falling edge on `ext_hrst_n` makes `h_cnt` read 0 after the third rising edge, counting from the first edge that samples the low level. This clear does not advance `v_cnt`. A held low level does not clear again.
- R9: With `sup_en` high, a falling edge on `ext_vrst_n` makes `v_cnt` read 0 with the same latency as R8, while `h_cnt` keeps counting. This clear takes priority over a line wrap in the same cycle.
- R10: With `sup_en` low, edges on `ext_hrst_n` and `ext_vrst_n` change neither counter.
- R11: While `rst` is high, the outputs are `h_cnt`=0, `v_cnt`=0, `fmt`=0, `fsc_en`=0, `csync_n`=1, `blank`=1 and `key`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 4x subcarrier |
| rst | input | 1 | Synchronous reset, active high |
| sel_a | input | 1 | First format select pin |
| sel_b | input | 1 | Second format select pin |
| line_full | input | 1 | 1: full interlaced line count, 0: one line fewer |
| ext_hrst_n | input | 1 | External horizontal reset, active low, asynchronous |
| ext_vrst_n | input | 1 | External vertical reset, active low, asynchronous |
| sup_en | input | 1 | Superimpose enable |
| h_cnt | output | HW | Pixel clock count within the line |
| v_cnt | output | VW | Line count within the field |
| fmt | output | 2 | Decoded format code |
| fsc_en | output | 1 | Subcarrier clock enable, one clock in four |
| csync_n | output | 1 | Composite sync, active low |
| blank | output | 1 | Blanking flag |
| key | output | 1 | Video switch key for superimpose |

## Verification
The counters and `fmt` take their new value on the first edge that sees new select or line inputs. `csync_n`, `blank` and `key` lag the count they describe by exactly one clock. An external reset edge shows up on the counters only on the third edge after it is first sampled. The reference model in the bench reproduces each of these delays: it keeps the previous count for the derived outputs and a three-entry history of each reset pin. Every output is compared on the falling clock edge of every cycle. Separate checks, placed at exactly the third edge, confirm that a lock clears the counter when superimpose is on and is ignored when it is off.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

  typedef enum logic [1:0] {
    FMT_NTSC_M = 2'd0,
    FMT_PAL_BG = 2'd1,
    FMT_PAL_M  = 2'd2
  } vid_fmt_e;

  // Pin pair decode; the unused combination falls back to NTSC-M.
  function automatic vid_fmt_e decode_fmt(input logic sel_a, input logic sel_b);
    case ({sel_a, sel_b})
      2'b00:   return FMT_PAL_BG;
      2'b01:   return FMT_PAL_M;
      default: return FMT_NTSC_M;
    endcase
  endfunction

endpackage

// File: rtl/vsg_edge_sync.sv
module vsg_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic fall
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '1;
    else     sh_q <= {sh_q[SYNC_STAGES-1:0], pin_n};
  end

  assign fall = sh_q[SYNC_STAGES] & ~sh_q[SYNC_STAGES-1];
endmodule

// File: rtl/vsg_fsc_div.sv
module vsg_fsc_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic en
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      en    <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      en    <= (cnt_q == LAST);
    end
  end
endmodule

// File: rtl/vsg_raster_cnt.sv
module vsg_raster_cnt #(
  parameter int HW = 11,
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] h_last,
  input  logic [VW-1:0] v_last,
  input  logic          h_clr,
  input  logic          v_clr,
  output logic [HW-1:0] h_q,
  output logic [VW-1:0] v_q
);
  logic h_wrap;
  assign h_wrap = (h_q >= h_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      if (h_clr)       h_q <= '0;
      else if (h_wrap) h_q <= '0;
      else             h_q <= h_q + 1'b1;

      if (v_clr)                v_q <= '0;
      else if (h_wrap && !h_clr) v_q <= (v_q >= v_last) ? '0 : v_q + 1'b1;
    end
  end
endmodule

// File: rtl/vsg_timing_top.sv
module vsg_timing_top
  import vsg_pkg::*;
#(
  parameter int H_TOT_525   = 910,
  parameter int H_TOT_625   = 1135,
  parameter int V_TOT_525   = 525,
  parameter int V_TOT_625   = 625,
  parameter int HSYNC_525   = 67,
  parameter int HSYNC_625   = 84,
  parameter int HBLANK_525  = 150,
  parameter int HBLANK_625  = 190,
  parameter int VBLANK_525  = 20,
  parameter int VBLANK_625  = 24,
  parameter int VSYNC_LINES = 3,
  parameter int FSC_DIV     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int H_MAX = (H_TOT_525 > H_TOT_625) ? H_TOT_525 : H_TOT_625,
  localparam int V_MAX = (V_TOT_525 > V_TOT_625) ? V_TOT_525 : V_TOT_625,
  localparam int HW = $clog2(H_MAX),
  localparam int VW = $clog2(V_MAX)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_a,
  input  logic          sel_b,
  input  logic          line_full,
  input  logic          ext_hrst_n,
  input  logic          ext_vrst_n,
  input  logic          sup_en,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt,
  output logic [1:0]    fmt,
  output logic          fsc_en,
  output logic          csync_n,
  output logic          blank,
  output logic          key
);
  localparam logic [HW-1:0] H_LAST_525 = HW'(H_TOT_525 - 1);
  localparam logic [HW-1:0] H_LAST_625 = HW'(H_TOT_625 - 1);
  localparam logic [VW-1:0] V_LAST_525 = VW'(V_TOT_525 - 1);
  localparam logic [VW-1:0] V_LAST_625 = VW'(V_TOT_625 - 1);
  localparam logic [VW-1:0] V_VSL      = VW'(VSYNC_LINES);

  vid_fmt_e fmt_c;
  logic     is625;
  assign fmt_c = decode_fmt(sel_a, sel_b);
  assign is625 = (fmt_c == FMT_PAL_BG);

  logic [HW-1:0] h_last, hs_len, hb_len;
  logic [VW-1:0] v_full_last, v_last, vb_len;
  always_comb begin
    h_last      = is625 ? H_LAST_625 : H_LAST_525;
    hs_len      = is625 ? HW'(HSYNC_625) : HW'(HSYNC_525);
    hb_len      = is625 ? HW'(HBLANK_625) : HW'(HBLANK_525);
    vb_len      = is625 ? VW'(VBLANK_625) : VW'(VBLANK_525);
    v_full_last = is625 ? V_LAST_625 : V_LAST_525;
    v_last      = line_full ? v_full_last : v_full_last - 1'b1;
  end

  // External reset pins: index 0 horizontal, index 1 vertical.
  logic [1:0] ext_pin_n, ext_fall;
  assign ext_pin_n = {ext_vrst_n, ext_hrst_n};

  for (genvar g = 0; g < 2; g++) begin : g_lock
    vsg_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst   (rst),
      .pin_n (ext_pin_n[g]),
      .fall  (ext_fall[g])
    );
  end

  logic h_clr, v_clr;
  assign h_clr = ext_fall[0] & sup_en;
  assign v_clr = ext_fall[1] & sup_en;

  vsg_raster_cnt #(.HW(HW), .VW(VW)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .h_last (h_last),
    .v_last (v_last),
    .h_clr  (h_clr),
    .v_clr  (v_clr),
    .h_q    (h_cnt),
    .v_q    (v_cnt)
  );

  vsg_fsc_div #(.DIV(FSC_DIV)) u_fsc (
    .clk (clk),
    .rst (rst),
    .en  (fsc_en)
  );

  logic blank_c, hsync_c, vsync_line;
  assign blank_c    = (h_cnt < hb_len) || (v_cnt < vb_len);
  assign hsync_c    = (h_cnt < hs_len);
  assign vsync_line = (v_cnt < V_VSL);

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt     <= 2'd0;
      csync_n <= 1'b1;
      blank   <= 1'b1;
      key     <= 1'b0;
    end else begin
      fmt     <= fmt_c;
      csync_n <= ~(hsync_c ^ vsync_line);
      blank   <= blank_c;
      key     <= sup_en & ~blank_c;
    end
  end
endmodule

// File: rtl/vsg_timing_chk.sv
module vsg_timing_chk #(
  parameter int HW = 11,
  parameter int VW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          sup_en,
  input logic [HW-1:0] h_cnt,
  input logic [VW-1:0] v_cnt,
  input logic          fsc_en,
  input logic          key
);
  AST_FSC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fsc_en |=> !fsc_en);                                               // R4

  AST_KEY_GATED: assert property (@(posedge clk) disable iff (rst)
    !sup_en |=> !key);                                                 // R7

  AST_H_STEP: assert property (@(posedge clk) disable iff (rst)
    (h_cnt != '0) |-> (h_cnt == HW'($past(h_cnt) + 1'b1)));            // R2

  AST_V_MOVE: assert property (@(posedge clk) disable iff (rst)
    !$stable(v_cnt) |-> (h_cnt == '0 || v_cnt == '0));                 // R3

  AST_V_STEP: assert property (@(posedge clk) disable iff (rst)
    (v_cnt != '0 && !$stable(v_cnt)) |-> (v_cnt == VW'($past(v_cnt) + 1'b1))); // R3
endmodule

bind vsg_timing_top vsg_timing_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .sup_en (sup_en),
  .h_cnt  (h_cnt),
  .v_cnt  (v_cnt),
  .fsc_en (fsc_en),
  .key    (key)
);

// File: tb/sim_vsg_timing_top.sv
`timescale 1ns/1ps
module sim_vsg_timing_top;
  localparam int HT5 = 40, HT6 = 50, VT5 = 15, VT6 = 19;
  localparam int HS5 = 4,  HS6 = 5,  HB5 = 8,  HB6 = 10;
  localparam int VB5 = 3,  VB6 = 4,  VSL = 2;
  localparam int HWB = $clog2(HT6);
  localparam int VWB = $clog2(VT6);

  logic clk = 1'b0;
  logic rst, sel_a, sel_b, line_full, ext_h, ext_v, sup;
  logic [HWB-1:0] h_cnt;
  logic [VWB-1:0] v_cnt;
  logic [1:0] fmt;
  logic fsc_en, csync_n, blank, key;

  always #2.5 clk = ~clk;

  vsg_timing_top #(
    .H_TOT_525(HT5), .H_TOT_625(HT6), .V_TOT_525(VT5), .V_TOT_625(VT6),
    .HSYNC_525(HS5), .HSYNC_625(HS6), .HBLANK_525(HB5), .HBLANK_625(HB6),
    .VBLANK_525(VB5), .VBLANK_625(VB6), .VSYNC_LINES(VSL)
  ) u0 (
    .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b), .line_full(line_full),
    .ext_hrst_n(ext_h), .ext_vrst_n(ext_v), .sup_en(sup),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .fmt(fmt), .fsc_en(fsc_en),
    .csync_n(csync_n), .blank(blank), .key(key)
  );

  int nchk = 0, nfail = 0;
  bit armed = 0, finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // R1 decode: 00 -> PAL-B/G (1), 01 -> PAL-M (2), else NTSC-M (0)
  function automatic int fmt_of(input logic a, input logic b);
    if (!a && !b) return 1;
    if (!a && b)  return 2;
    return 0;
  endfunction

  // Behavioural reference model
  int mh, mv, mdiv, efsc, ecs, ebl, ekey, efmt;
  int hh[3], vh[3];
  always @(posedge clk) begin
    armed <= 1'b1;
    if (rst) begin
      mh = 0; mv = 0; mdiv = 0; efsc = 0; ecs = 1; ebl = 1; ekey = 0; efmt = 0;
      for (int i = 0; i < 3; i++) begin hh[i] = 1; vh[i] = 1; end
    end else begin
      int f, htot, vtot, hb, vb, hs, hsa, hfall, vfall, wrap;
      f    = fmt_of(sel_a, sel_b);
      htot = (f == 1) ? HT6 : HT5;
      vtot = ((f == 1) ? VT6 : VT5) - (line_full ? 0 : 1);
      hb   = (f == 1) ? HB6 : HB5;
      vb   = (f == 1) ? VB6 : VB5;
      hs   = (f == 1) ? HS6 : HS5;
      ebl  = (mh < hb || mv < vb) ? 1 : 0;
      hsa  = (mh < hs) ? 1 : 0;
      ecs  = (mv < VSL) ? hsa : 1 - hsa;
      ekey = (sup && !ebl) ? 1 : 0;
      efmt = f;
      efsc = (mdiv == 3) ? 1 : 0;
      mdiv = (mdiv + 1) % 4;
      hfall = (sup && hh[2] == 1 && hh[1] == 0) ? 1 : 0;
      vfall = (sup && vh[2] == 1 && vh[1] == 0) ? 1 : 0;
      hh[2] = hh[1]; hh[1] = hh[0]; hh[0] = ext_h;
      vh[2] = vh[1]; vh[1] = vh[0]; vh[0] = ext_v;
      wrap = (mh >= htot - 1) ? 1 : 0;
      if (hfall || wrap) mh = 0; else mh = mh + 1;
      if (vfall) mv = 0;
      else if (wrap && !hfall) mv = (mv >= vtot - 1) ? 0 : mv + 1;
    end
  end

  always @(negedge clk) begin
    if (armed && !finished) begin
      chk("R2 h_cnt", int'(h_cnt), mh);
      chk("R3 v_cnt", int'(v_cnt), mv);
      chk("R1 fmt", int'(fmt), efmt);
      chk("R4 fsc_en", int'(fsc_en), efsc);
      chk("R5 blank", int'(blank), ebl);
      chk("R6 csync_n", int'(csync_n), ecs);
      chk("R7 key", int'(key), ekey);
    end
  end

  // Drive resets low; sample on the third edge after the first low sample.
  task automatic pulse(input bit doh, input bit dov);
    @(negedge clk);
    if (doh) ext_h = 1'b0;
    if (dov) ext_v = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (sup) begin
      if (doh) chk("R8 lock h", int'(h_cnt), 0);
      if (dov) chk("R9 lock v", int'(v_cnt), 0);
    end else begin
      chk("R10 ignore h", int'(h_cnt), mh);
      chk("R10 ignore v", int'(v_cnt), mv);
    end
    repeat (6) @(negedge clk);
    if (doh) chk("R8 held low", int'(h_cnt), sup ? 6 : mh);
    ext_h = 1'b1; ext_v = 1'b1;
    repeat (23) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    rst = 1; sel_a = 1; sel_b = 1; line_full = 1; ext_h = 1; ext_v = 1; sup = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 h", int'(h_cnt), 0);   chk("R11 v", int'(v_cnt), 0);
    chk("R11 fmt", int'(fmt), 0);   chk("R11 fsc", int'(fsc_en), 0);
    chk("R11 cs", int'(csync_n), 1); chk("R11 bl", int'(blank), 1);
    chk("R11 key", int'(key), 0);
    rst = 0;
    repeat (1300) @(negedge clk);              // NTSC-M full
    line_full = 0; repeat (1300) @(negedge clk); // NTSC-M one line fewer
    sel_a = 0; sel_b = 0; line_full = 1; repeat (2000) @(negedge clk);
    line_full = 0; repeat (2000) @(negedge clk);
    sel_a = 0; sel_b = 1; line_full = 1; repeat (700) @(negedge clk);
    chk("R1 PAL-M code", int'(fmt), 2);
    sel_a = 1; sel_b = 0; repeat (700) @(negedge clk);
    chk("R1 fallback code", int'(fmt), 0);
    sel_a = 1; sel_b = 1; sup = 1; repeat (300) @(negedge clk);
    pulse(1, 0); repeat (57) @(negedge clk);
    pulse(0, 1); repeat (313) @(negedge clk);
    pulse(1, 1);
    sel_a = 0; sel_b = 0; repeat (211) @(negedge clk);
    pulse(1, 0); pulse(0, 1);
    sup = 0; repeat (17) @(negedge clk);
    pulse(1, 0); pulse(0, 1); pulse(1, 1);
    for (int i = 0; i < 10; i++) begin
      sup = ~sup; repeat (37) @(negedge clk);
    end
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule